// File: doc/BRIEF.md
# Machine Trap Capture Unit

This unit holds the two machine-level registers that record where a trap happened and what caused it: the saved program counter and the trap value. When the trap-taken strobe is high, both registers are loaded on the next rising clock edge. The saved program counter receives the address of the instruction that was interrupted or that raised an exception. The trap value register receives a value chosen from the trap's class: the faulting virtual address, the raw instruction bits, or zero.

Outside a trap, only a software write through the CSR port can change either register. The saved program counter is always kept aligned, whether it is loaded by hardware or by software. Cause prioritisation, privilege changes and vectoring are handled elsewhere. This block only captures the values.

Top module: `mtrap_capture`

## Requirements
- R1: When reset is asserted (rst_n low), epc_o and tval_o read zero, and they still read zero on the first clock edge after reset is released.
- R2: On the rising edge after trap_take is sampled high, epc_o takes the aligned trap_pc. This holds for interrupts (trap_is_irq=1) and for exceptions (trap_is_irq=0).
- R3: Bit 0 of epc_o is always zero. When the parameter HAS_C is 0, bit 1 is also always zero. The same alignment applies to trap loads and to software writes.
- R4: For an exception (trap_is_irq=0) whose cause code is 0, 1, 3, 4, 5, 6, 7, 12, 13 or 15, tval_o takes fault_addr on the edge after the trap. These codes cover misaligned fetch, load and store addresses, access faults, page faults and breakpoints.
- R5: For an exception with cause code 2 (illegal instruction), tval_o takes fault_insn zero-extended to XLEN bits when KEEP_INSN is 1, and zero when KEEP_INSN is 0.
- R6: For an interrupt with any cause code, and for an exception whose cause code is outside the sets in R4 and R5, tval_o is written with zero.
- R7: In a cycle with neither trap_take nor sw_we, both registers keep their values. Changes on trap_pc, fault_addr, fault_insn, trap_cause and sw_wdata have no effect in such a cycle.
- R8: With sw_we high and no trap, address 12'h341 (EPC_CSR) loads epc_o from sw_wdata with the R3 alignment, and address 12'h343 (TVAL_CSR) loads tval_o unchanged. Any other address changes neither register.
- R9: When trap_take and sw_we are both high in the same cycle, the trap update is applied and the software write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_take | input | 1 | A trap into machine mode is taken this cycle |
| trap_is_irq | input | 1 | 1 means interrupt, 0 means exception |
| trap_cause | input | CAUSE_W | Cause code of the trap |
| trap_pc | input | XLEN | Address of the affected instruction |
| fault_addr | input | XLEN | Faulting virtual address |
| fault_insn | input | ILEN | Raw bits of the offending instruction |
| sw_we | input | 1 | Software CSR write enable |
| sw_addr | input | ADDR_W | Software CSR address |
| sw_wdata | input | XLEN | Software CSR write data |
| epc_o | output | XLEN | Saved program counter |
| tval_o | output | XLEN | Trap value |

## Verification
The hardest case to reach is a trap and a software write in the same cycle, particularly when the write targets the register whose trap value is zero. If the write leaked through, it would show up as a nonzero trap value that looks plausible. The stimulus drives these collisions on purpose, for both target addresses, with interrupt and exception causes. A long randomised phase then overlaps the strobes freely, with the fault inputs changing every cycle. A second instance built with HAS_C=0 and KEEP_INSN=0 runs on the same stimulus, so the stricter alignment and the zero fallback are checked against an independent model.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam int unsigned CS_FETCH_MISALIGN = 0;
    localparam int unsigned CS_FETCH_ACCESS   = 1;
    localparam int unsigned CS_ILLEGAL        = 2;
    localparam int unsigned CS_BREAK          = 3;
    localparam int unsigned CS_LOAD_MISALIGN  = 4;
    localparam int unsigned CS_LOAD_ACCESS    = 5;
    localparam int unsigned CS_STORE_MISALIGN = 6;
    localparam int unsigned CS_STORE_ACCESS   = 7;
    localparam int unsigned CS_FETCH_PAGE     = 12;
    localparam int unsigned CS_LOAD_PAGE      = 13;
    localparam int unsigned CS_STORE_PAGE     = 15;

    // Exception causes whose trap value is the faulting address.
    function automatic logic cause_reports_addr(input int unsigned code);
        case (code)
            CS_FETCH_MISALIGN, CS_FETCH_ACCESS, CS_BREAK,
            CS_LOAD_MISALIGN, CS_LOAD_ACCESS,
            CS_STORE_MISALIGN, CS_STORE_ACCESS,
            CS_FETCH_PAGE, CS_LOAD_PAGE, CS_STORE_PAGE: return 1'b1;
            default:                                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mtrap_tval_sel.sv
module mtrap_tval_sel #(
    parameter int XLEN      = 32,
    parameter int ILEN      = 32,
    parameter int CAUSE_W   = 5,
    parameter bit KEEP_INSN = 1'b1
) (
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic [ILEN-1:0]    fault_insn,
    output logic [XLEN-1:0]    tval
);
    import mtrap_pkg::*;

    logic [XLEN-1:0] insn_x;

    generate
        if (ILEN >= XLEN) begin : g_insn_trunc
            assign insn_x = fault_insn[XLEN-1:0];
        end else begin : g_insn_zext
            assign insn_x = {{(XLEN-ILEN){1'b0}}, fault_insn};
        end
    endgenerate

    always_comb begin
        tval = '0;
        if (!is_irq) begin
            if (cause_reports_addr(32'(cause))) begin
                tval = fault_addr;
            end else if (32'(cause) == CS_ILLEGAL && KEEP_INSN) begin
                tval = insn_x;
            end
        end
    end

endmodule

// File: rtl/mtrap_epc_align.sv
module mtrap_epc_align #(
    parameter int XLEN  = 32,
    parameter bit HAS_C = 1'b1
) (
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] aligned
);
    generate
        if (HAS_C) begin : g_half
            assign aligned = {raw[XLEN-1:1], 1'b0};
        end else begin : g_word
            assign aligned = {raw[XLEN-1:2], 2'b00};
        end
    endgenerate
endmodule

// File: rtl/mtrap_capture.sv
module mtrap_capture #(
    parameter int              XLEN      = 32,
    parameter int              ILEN      = 32,
    parameter int              CAUSE_W   = 5,
    parameter int              ADDR_W    = 12,
    parameter bit              HAS_C     = 1'b1,
    parameter bit              KEEP_INSN = 1'b1,
    parameter logic [ADDR_W-1:0] EPC_CSR  = 12'h341,
    parameter logic [ADDR_W-1:0] TVAL_CSR = 12'h343
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_take,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic [ILEN-1:0]    fault_insn,
    input  logic               sw_we,
    input  logic [ADDR_W-1:0]  sw_addr,
    input  logic [XLEN-1:0]    sw_wdata,
    output logic [XLEN-1:0]    epc_o,
    output logic [XLEN-1:0]    tval_o
);

    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] tval;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [XLEN-1:0] trap_epc;
    logic [XLEN-1:0] sw_epc;
    logic [XLEN-1:0] trap_tval;

    mtrap_epc_align #(.XLEN(XLEN), .HAS_C(HAS_C)) u_align_trap (
        .raw     (trap_pc),
        .aligned (trap_epc)
    );

    mtrap_epc_align #(.XLEN(XLEN), .HAS_C(HAS_C)) u_align_sw (
        .raw     (sw_wdata),
        .aligned (sw_epc)
    );

    mtrap_tval_sel #(
        .XLEN(XLEN), .ILEN(ILEN), .CAUSE_W(CAUSE_W), .KEEP_INSN(KEEP_INSN)
    ) u_tval_sel (
        .is_irq     (trap_is_irq),
        .cause      (trap_cause),
        .fault_addr (fault_addr),
        .fault_insn (fault_insn),
        .tval       (trap_tval)
    );

    always_comb begin
        regs_d = regs_q;
        if (trap_take) begin
            regs_d.epc  = trap_epc;
            regs_d.tval = trap_tval;
        end else if (sw_we) begin
            if (sw_addr == EPC_CSR) begin
                regs_d.epc = sw_epc;
            end
            if (sw_addr == TVAL_CSR) begin
                regs_d.tval = sw_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign epc_o  = regs_q.epc;
    assign tval_o = regs_q.tval;

endmodule

// File: rtl/mtrap_capture_chk.sv
module mtrap_capture_chk #(
    parameter int              XLEN     = 32,
    parameter int              CAUSE_W  = 5,
    parameter int              ADDR_W   = 12,
    parameter bit              HAS_C    = 1'b1,
    parameter logic [ADDR_W-1:0] EPC_CSR  = 12'h341,
    parameter logic [ADDR_W-1:0] TVAL_CSR = 12'h343
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trap_take,
    input logic               trap_is_irq,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [XLEN-1:0]    trap_pc,
    input logic [XLEN-1:0]    fault_addr,
    input logic               sw_we,
    input logic [ADDR_W-1:0]  sw_addr,
    input logic [XLEN-1:0]    sw_wdata,
    input logic [XLEN-1:0]    epc_o,
    input logic [XLEN-1:0]    tval_o
);
    import mtrap_pkg::*;

    localparam logic [XLEN-1:0] EPC_MASK = HAS_C ? ~XLEN'(1) : ~XLEN'(3);

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (epc_o == '0 && tval_o == '0));

    p_epc_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> epc_o == ($past(trap_pc) & EPC_MASK));

    p_epc_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        epc_o[0] == 1'b0 && (HAS_C || epc_o[1] == 1'b0));

    p_tval_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && !trap_is_irq && cause_reports_addr(32'(trap_cause)))
        |=> tval_o == $past(fault_addr));

    p_tval_irq_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && trap_is_irq) |=> tval_o == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_take && !sw_we) |=> ($stable(epc_o) && $stable(tval_o)));

    p_sw_epc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_take && sw_we && sw_addr == EPC_CSR)
        |=> epc_o == ($past(sw_wdata) & EPC_MASK));

    p_sw_tval_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_take && sw_we && sw_addr == TVAL_CSR)
        |=> tval_o == $past(sw_wdata));

    p_trap_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && trap_is_irq && sw_we && sw_addr == TVAL_CSR)
        |=> tval_o == '0);

endmodule

bind mtrap_capture mtrap_capture_chk #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W), .HAS_C(HAS_C),
    .EPC_CSR(EPC_CSR), .TVAL_CSR(TVAL_CSR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_take   (trap_take),
    .trap_is_irq (trap_is_irq),
    .trap_cause  (trap_cause),
    .trap_pc     (trap_pc),
    .fault_addr  (fault_addr),
    .sw_we       (sw_we),
    .sw_addr     (sw_addr),
    .sw_wdata    (sw_wdata),
    .epc_o       (epc_o),
    .tval_o      (tval_o)
);

// File: tb/mtrap_capture_tb.sv
`timescale 1ns/1ps
module mtrap_capture_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_take = 1'b0;
    logic        trap_is_irq = 1'b0;
    logic [4:0]  trap_cause = '0;
    logic [31:0] trap_pc = '0;
    logic [31:0] fault_addr = '0;
    logic [31:0] fault_insn = '0;
    logic        sw_we = 1'b0;
    logic [11:0] sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] epc_o, tval_o, epc_a, tval_a;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_epc = '0, m_tval = '0, a_epc = '0, a_tval = '0;

    always #4 clk = ~clk;

    mtrap_capture u_dut (
        .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_is_irq(trap_is_irq),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .fault_addr(fault_addr),
        .fault_insn(fault_insn), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .epc_o(epc_o), .tval_o(tval_o)
    );

    mtrap_capture #(.HAS_C(1'b0), .KEEP_INSN(1'b0)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_is_irq(trap_is_irq),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .fault_addr(fault_addr),
        .fault_insn(fault_insn), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .epc_o(epc_a), .tval_o(tval_a)
    );

    function automatic logic [31:0] want_tval(input logic irq, input logic [4:0] c,
                                              input logic [31:0] addr,
                                              input logic [31:0] insn,
                                              input bit keep);
        if (irq) return 32'h0;
        if (c inside {5'd0, 5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15})
            return addr;
        if (c == 5'd2) return keep ? insn : 32'h0;
        return 32'h0;
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "epc", epc_o, m_epc);
        cmp(tag, "tval", tval_o, m_tval);
        cmp(tag, "alt epc", epc_a, a_epc);
        cmp(tag, "alt tval", tval_a, a_tval);
    endtask

    // One clock: drive after the falling edge, update the model at the
    // rising edge, compare at the next falling edge.
    task automatic step(input string tag, input logic tk, input logic irq,
                        input logic [4:0] c, input logic [31:0] pc,
                        input logic [31:0] addr, input logic [31:0] insn,
                        input logic we, input logic [11:0] a, input logic [31:0] d);
        trap_take = tk; trap_is_irq = irq; trap_cause = c; trap_pc = pc;
        fault_addr = addr; fault_insn = insn; sw_we = we; sw_addr = a; sw_wdata = d;
        @(posedge clk);
        if (tk) begin
            m_epc  = pc & 32'hFFFF_FFFE;
            a_epc  = pc & 32'hFFFF_FFFC;
            m_tval = want_tval(irq, c, addr, insn, 1'b1);
            a_tval = want_tval(irq, c, addr, insn, 1'b0);
        end else if (we) begin
            if (a == 12'h341) begin
                m_epc = d & 32'hFFFF_FFFE;
                a_epc = d & 32'hFFFF_FFFC;
            end
            if (a == 12'h343) begin
                m_tval = d;
                a_tval = d;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step("R1", 0, 0, 5'd0, 32'h1111_1113, 32'h2222_2222, 32'h3333_3333, 0, 12'h0, 32'h0);

        // Address-reporting exception causes
        foreach (ADDR_CAUSES[i])
            step("R4", 1, 0, ADDR_CAUSES[i], 32'h8000_0103 + 32'(i) * 16,
                 32'hDEAD_0001 + 32'(i), 32'h0000_0013, 0, 12'h0, 32'h0);

        // Illegal instruction: bits in main, zero in alt
        step("R5", 1, 0, 5'd2, 32'h8000_2002, 32'hAAAA_5555, 32'hFFFF_FFFF, 0, 12'h0, 32'h0);
        step("R5", 1, 0, 5'd2, 32'h8000_2006, 32'h1234_5678, 32'h0051_0533, 0, 12'h0, 32'h0);

        // Interrupts with codes that would report an address as exceptions
        step("R6", 1, 1, 5'd3, 32'h8000_3007, 32'hBEEF_BEEF, 32'h1, 0, 12'h0, 32'h0);
        step("R6", 1, 1, 5'd7, 32'h8000_300B, 32'hBEEF_BEEF, 32'h1, 0, 12'h0, 32'h0);
        step("R2", 1, 1, 5'd11, 32'h0000_0FFF, 32'hCAFE_0000, 32'h1, 0, 12'h0, 32'h0);
        // Exceptions outside the address and illegal sets
        step("R6", 1, 0, 5'd8, 32'h8000_4000, 32'h5555_5555, 32'h2, 0, 12'h0, 32'h0);
        step("R6", 1, 0, 5'd11, 32'h8000_4004, 32'h5555_5555, 32'h2, 0, 12'h0, 32'h0);
        step("R6", 1, 0, 5'd14, 32'h8000_4008, 32'h5555_5555, 32'h2, 0, 12'h0, 32'h0);

        // Software writes
        step("R8", 0, 0, 5'd0, 32'h0, 32'h0, 32'h0, 1, 12'h341, 32'h1234_5677);
        step("R3", 0, 0, 5'd0, 32'h0, 32'h0, 32'h0, 1, 12'h341, 32'hFFFF_FFFF);
        step("R8", 0, 0, 5'd0, 32'h0, 32'h0, 32'h0, 1, 12'h343, 32'h0BAD_F00D);
        step("R8", 0, 0, 5'd0, 32'h0, 32'h0, 32'h0, 1, 12'h342, 32'h7777_7777);
        step("R8", 0, 0, 5'd0, 32'h0, 32'h0, 32'h0, 1, 12'h741, 32'h6666_6666);

        // Idle with busy inputs
        for (int k = 0; k < 4; k++)
            step("R7", 0, k[0], 5'(k), 32'hF0F0_F0F1 ^ 32'(k), 32'h1357_9BDF,
                 32'h2468_ACE0, 0, 12'h341, 32'h9999_9999);

        // Trap and software write together
        step("R9", 1, 1, 5'd7, 32'h4000_0010, 32'hFFFF_0000, 32'h0, 1, 12'h343, 32'hFEED_FACE);
        step("R9", 1, 0, 5'd5, 32'h4000_0022, 32'h0ABC_DEF0, 32'h0, 1, 12'h341, 32'h5555_5555);
        step("R9", 1, 0, 5'd2, 32'h4000_0033, 32'h0, 32'hC0DE_C0DE, 1, 12'h343, 32'h1111_1111);

        // Randomised mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0] sel;
            logic [11:0] adr;
            sel = 2'($urandom_range(0, 3));
            adr = (sel == 2'd0) ? 12'h341 : (sel == 2'd1) ? 12'h343 : 12'($urandom);
            step("R2", ($urandom_range(0, 2) == 0), 1'($urandom), 5'($urandom),
                 $urandom, $urandom, $urandom, 1'($urandom), adr, $urandom);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [4:0] ADDR_CAUSES [10] =
        '{5'd0, 5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule